// File: doc/BRIEF.md
# Cache Miss Tracking Entry

This block is one slot of a cache's miss-handling file. It holds one outstanding line miss: the line address, the access size, a few status flags, and an ordered list of the requests that wait for the fill. The cache allocates the entry with the request that missed. It then attaches further requests that hit the same line while the miss is open. These come from the processor side or from the snoop side. The cache marks the entry as sent to memory when the miss request leaves, and drains the waiting requests one at a time once the data is back. When the list is empty, the entry is released.

Each queued request keeps its id, an invalidate marker, a needs-exclusive marker and a bit saying which side it came from. Added requests normally go to the tail. One case is different. The entry may have gone out asking only for a shared copy while some waiting request wants ownership. If a snoop invalidate arrives in that state, it is placed just before the first waiting request that needs ownership. That request and the ones behind it are then served by a later, separate fetch, after the line has been given up.

When several commands come in the same cycle, they are taken in this order: allocate, release, add, pop. The issue strobe is taken whenever the entry holds a miss and neither allocate nor release is requested.

Top module: `miss_entry`

## Requirements
- R1: After reset the entry is empty, with entry_valid, tgt_count and in_service all 0. An allocate to an empty entry stores the address, the size, the uncacheable flag and the first request's needs-exclusive bit. It clears in_service and sets tgt_count to 1. The stored first request is marked as coming from the processor side (pop_cpu = 1).
- R2: An allocate to an entry that is already valid is ignored. The address, flags and count stay as they were.
- R3: An add that does not meet the R4 condition places the request at the tail of the list, keeps its side bit, and raises tgt_count by one on the next cycle.
- R4: An added request is inserted just before the first queued request whose needs-exclusive bit is 1 when all of the following hold: in_service is 1, issued_excl is 0, needs_excl is 1, add_cpu is 0 and add_inval is 1. It goes at the tail when no queued request has that bit set. All other requests keep their relative order.
- R5: When any one of the five R4 conditions is false, the added request goes at the tail.
- R6: needs_excl is sticky while the entry lives. Each accepted add ORs its own needs-exclusive bit into it.
- R7: An issue strobe on a valid entry sets in_service and loads issue_excl into issued_excl.
- R8: A pop on a non-empty list pulses pop_ack one cycle later. It shows the head request's id, invalidate, needs-exclusive and side bits, and lowers tgt_count by one. A pop on an empty list pulses pop_err instead, and nothing else changes.
- R9: The list holds 8 requests, and list_full is 1 when it holds 8. An add to a full list pulses add_err one cycle later and leaves the count and the list order unchanged.
- R10: A release with tgt_count equal to 0 clears entry_valid and in_service. A release while requests are still queued is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocate the entry for a new miss |
| alloc_addr | input | 32 | Line address of the miss |
| alloc_size | input | 3 | Access size code |
| alloc_id | input | 4 | Id of the first request |
| alloc_excl | input | 1 | First request needs exclusive ownership |
| alloc_inval | input | 1 | First request is an invalidate |
| alloc_uncached | input | 1 | Access is uncacheable |
| add_valid | input | 1 | Attach a request to the open miss |
| add_id | input | 4 | Id of the added request |
| add_excl | input | 1 | Added request needs exclusive ownership |
| add_inval | input | 1 | Added request is an invalidate |
| add_cpu | input | 1 | 1 = processor side, 0 = snoop side |
| issue_valid | input | 1 | Miss request sent to memory |
| issue_excl | input | 1 | Request was sent asking for ownership |
| pop_valid | input | 1 | Remove the head request |
| dealloc_valid | input | 1 | Release the entry |
| entry_valid | output | 1 | Entry holds a miss |
| line_addr | output | 32 | Stored line address |
| line_size | output | 3 | Stored size code |
| needs_excl | output | 1 | Some request needs ownership |
| uncacheable | output | 1 | Stored uncacheable flag |
| in_service | output | 1 | Miss request has been sent |
| issued_excl | output | 1 | Sent request asked for ownership |
| tgt_count | output | 4 | Number of queued requests |
| list_full | output | 1 | List holds 8 requests |
| add_err | output | 1 | Pulse: add refused, list full |
| pop_ack | output | 1 | Pulse: pop served |
| pop_err | output | 1 | Pulse: pop refused, list empty |
| pop_id | output | 4 | Id of the popped request |
| pop_excl | output | 1 | Popped request needs ownership |
| pop_inval | output | 1 | Popped request is an invalidate |
| pop_cpu | output | 1 | Popped request came from the processor side |

## Verification
The hardest case to reach is the reordered insertion. It needs a particular history: a shared-mode issue, at least one ownership-seeking request already queued, and a snoop-side invalidate arriving afterwards. The order can only be seen by draining the list. The stimulus builds a six-deep list with the first ownership request at every possible position, including none, then inserts the invalidate and pops everything. It also runs all 32 combinations of the five enabling conditions to show that the request goes at the tail whenever any one of them is false.

// File: rtl/miss_entry_pkg.sv
// Shared types for the miss tracking entry.
// Assumes: request ids are TID_W bits wide; one queued request is one tgt_t.
package miss_entry_pkg;
    parameter int unsigned TID_W = 4;

    typedef struct packed {
        logic [TID_W-1:0] id;
        logic             need_excl;
        logic             inval;
        logic             cpu_side;
    } tgt_t;
endpackage

// File: rtl/miss_entry_locate.sv
// Finds the first queued request that wants exclusive ownership.
// Assumes: slots below count are valid. If none matches, the result is count (tail).
module miss_entry_locate
    import miss_entry_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  tgt_t             slots [DEPTH],
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] pos
);
    // Priority scan from the head for the first ownership request
    always_comb begin
        logic found;
        found = 1'b0;
        pos   = count;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && (CNT_W'(i) < count) && slots[i].need_excl) begin
                pos   = CNT_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/miss_entry_queue.sv
// Fixed-depth ordered request list with insert-at-position and pop-from-head.
// Assumes: the caller never inserts when full, never pops when empty,
// and raises at most one of init/insert/pop per cycle.
module miss_entry_queue
    import miss_entry_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_en,
    input  tgt_t             init_tgt,
    input  logic             ins_en,
    input  logic [CNT_W-1:0] ins_pos,
    input  tgt_t             ins_tgt,
    input  logic             pop_en,
    output tgt_t             slots [DEPTH],
    output logic [CNT_W-1:0] count
);
    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (init_en) count <= CNT_W'(1);
        else if (ins_en)  count <= count + CNT_W'(1);
        else if (pop_en)  count <= count - CNT_W'(1);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        tgt_t from_below;
        tgt_t from_above;
        if (g == 0) begin : g_bot
            assign from_below = '0;
        end else begin : g_mid
            assign from_below = slots[g-1];
        end
        if (g == DEPTH - 1) begin : g_top
            assign from_above = '0;
        end else begin : g_low
            assign from_above = slots[g+1];
        end

        // One slot: load, keep, shift up on insert, shift down on pop
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (init_en) begin
                slots[g] <= (g == 0) ? init_tgt : '0;
            end else if (ins_en) begin
                if (CNT_W'(g) == ins_pos)     slots[g] <= ins_tgt;
                else if (CNT_W'(g) > ins_pos) slots[g] <= from_below;
            end else if (pop_en) begin
                slots[g] <= from_above;
            end
        end
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    assert_ins_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> count < CNT_W'(DEPTH));
    assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> count != '0);
endmodule

// File: rtl/miss_entry.sv
// One cache miss tracking entry: line status flags plus the ordered list of
// requests waiting on the fill. A snoop invalidate that arrives during a
// shared-mode fetch goes ahead of the first ownership request.
// Assumes: command priority is allocate > release > add > pop; issue is taken
// on a valid entry when neither allocate nor release is requested.
module miss_entry
    import miss_entry_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SIZE_W = 3,
    parameter int unsigned DEPTH  = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_size,
    input  logic [TID_W-1:0]  alloc_id,
    input  logic              alloc_excl,
    input  logic              alloc_inval,
    input  logic              alloc_uncached,
    input  logic              add_valid,
    input  logic [TID_W-1:0]  add_id,
    input  logic              add_excl,
    input  logic              add_inval,
    input  logic              add_cpu,
    input  logic              issue_valid,
    input  logic              issue_excl,
    input  logic              pop_valid,
    input  logic              dealloc_valid,
    output logic              entry_valid,
    output logic [ADDR_W-1:0] line_addr,
    output logic [SIZE_W-1:0] line_size,
    output logic              needs_excl,
    output logic              uncacheable,
    output logic              in_service,
    output logic              issued_excl,
    output logic [CNT_W-1:0]  tgt_count,
    output logic              list_full,
    output logic              add_err,
    output logic              pop_ack,
    output logic              pop_err,
    output logic [TID_W-1:0]  pop_id,
    output logic              pop_excl,
    output logic              pop_inval,
    output logic              pop_cpu
);
    tgt_t             slots [DEPTH];
    logic [CNT_W-1:0] loc_pos;
    logic [CNT_W-1:0] ins_pos;
    logic alloc_acc, dealloc_acc, add_req, add_acc, add_rej;
    logic pop_req, pop_acc, pop_rej, issue_acc, reorder;
    tgt_t init_tgt, add_tgt;

    assign list_full = (tgt_count == CNT_W'(DEPTH));

    // Command decode with fixed priority
    always_comb begin
        alloc_acc   = alloc_valid && !entry_valid;
        dealloc_acc = !alloc_valid && dealloc_valid && entry_valid && (tgt_count == '0);
        add_req     = !alloc_valid && !dealloc_valid && add_valid && entry_valid;
        add_acc     = add_req && !list_full;
        add_rej     = add_req && list_full;
        pop_req     = !alloc_valid && !dealloc_valid && !add_valid && pop_valid;
        pop_acc     = pop_req && (tgt_count != '0);
        pop_rej     = pop_req && (tgt_count == '0);
        issue_acc   = issue_valid && entry_valid && !alloc_valid && !dealloc_valid;
    end

    // Insertion slot: reordered invalidate or plain tail append
    always_comb begin
        reorder  = in_service && !issued_excl && needs_excl && !add_cpu && add_inval;
        ins_pos  = reorder ? loc_pos : tgt_count;
        init_tgt = '{id: alloc_id, need_excl: alloc_excl, inval: alloc_inval, cpu_side: 1'b1};
        add_tgt  = '{id: add_id, need_excl: add_excl, inval: add_inval, cpu_side: add_cpu};
    end

    miss_entry_locate #(.DEPTH(DEPTH)) u_locate (
        .slots (slots),
        .count (tgt_count),
        .pos   (loc_pos)
    );

    miss_entry_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_en  (alloc_acc),
        .init_tgt (init_tgt),
        .ins_en   (add_acc),
        .ins_pos  (ins_pos),
        .ins_tgt  (add_tgt),
        .pop_en   (pop_acc),
        .slots    (slots),
        .count    (tgt_count)
    );

    // Line status and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_valid <= 1'b0;
            line_addr   <= '0;
            line_size   <= '0;
            needs_excl  <= 1'b0;
            uncacheable <= 1'b0;
            in_service  <= 1'b0;
            issued_excl <= 1'b0;
        end else if (alloc_acc) begin
            entry_valid <= 1'b1;
            line_addr   <= alloc_addr;
            line_size   <= alloc_size;
            needs_excl  <= alloc_excl;
            uncacheable <= alloc_uncached;
            in_service  <= 1'b0;
            issued_excl <= 1'b0;
        end else if (dealloc_acc) begin
            entry_valid <= 1'b0;
            in_service  <= 1'b0;
        end else begin
            if (add_acc)   needs_excl <= needs_excl | add_excl;
            if (issue_acc) begin
                in_service  <= 1'b1;
                issued_excl <= issue_excl;
            end
        end
    end

    // Registered pop and error responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_err   <= 1'b0;
            pop_ack   <= 1'b0;
            pop_err   <= 1'b0;
            pop_id    <= '0;
            pop_excl  <= 1'b0;
            pop_inval <= 1'b0;
            pop_cpu   <= 1'b0;
        end else begin
            add_err <= add_rej;
            pop_ack <= pop_acc;
            pop_err <= pop_rej;
            if (pop_acc) begin
                pop_id    <= slots[0].id;
                pop_excl  <= slots[0].need_excl;
                pop_inval <= slots[0].inval;
                pop_cpu   <= slots[0].cpu_side;
            end
        end
    end

    assert_alloc_init_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_acc |=> (tgt_count == CNT_W'(1)) && !in_service && slots[0].cpu_side);
    assert_alloc_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && entry_valid) |=> $stable(line_addr) && $stable(line_size));
    assert_add_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        add_acc |=> tgt_count == $past(tgt_count) + CNT_W'(1));
    assert_insert_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        add_acc |-> ins_pos <= tgt_count);
    assert_sticky_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && needs_excl) |=> needs_excl);
    assert_issue_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue_acc |=> in_service && (issued_excl == $past(issue_excl)));
    assert_pop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_rej |=> pop_err && !pop_ack && (tgt_count == '0));
    assert_full_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
        add_rej |=> add_err && $stable(tgt_count));
    assert_dealloc_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid && dealloc_valid && !alloc_valid && tgt_count != '0) |=> entry_valid);
endmodule

// File: tb/tb_miss_entry.sv
module tb_miss_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, alloc_excl = 0, alloc_inval = 0, alloc_uncached = 0;
    logic [31:0] alloc_addr = '0;
    logic [2:0]  alloc_size = '0;
    logic [3:0]  alloc_id = '0, add_id = '0;
    logic        add_valid = 0, add_excl = 0, add_inval = 0, add_cpu = 0;
    logic        issue_valid = 0, issue_excl = 0, pop_valid = 0, dealloc_valid = 0;
    logic        entry_valid, needs_excl, uncacheable, in_service, issued_excl, list_full;
    logic [31:0] line_addr;
    logic [2:0]  line_size;
    logic [3:0]  tgt_count, pop_id;
    logic        add_err, pop_ack, pop_err, pop_excl, pop_inval, pop_cpu;

    always #4 clk = ~clk;

    miss_entry dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_size(alloc_size),
        .alloc_id(alloc_id), .alloc_excl(alloc_excl), .alloc_inval(alloc_inval),
        .alloc_uncached(alloc_uncached),
        .add_valid(add_valid), .add_id(add_id), .add_excl(add_excl),
        .add_inval(add_inval), .add_cpu(add_cpu),
        .issue_valid(issue_valid), .issue_excl(issue_excl),
        .pop_valid(pop_valid), .dealloc_valid(dealloc_valid),
        .entry_valid(entry_valid), .line_addr(line_addr), .line_size(line_size),
        .needs_excl(needs_excl), .uncacheable(uncacheable), .in_service(in_service),
        .issued_excl(issued_excl), .tgt_count(tgt_count), .list_full(list_full),
        .add_err(add_err), .pop_ack(pop_ack), .pop_err(pop_err), .pop_id(pop_id),
        .pop_excl(pop_excl), .pop_inval(pop_inval), .pop_cpu(pop_cpu)
    );

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    // Reference list kept by the bench
    int m_id [8];
    bit m_ex [8], m_inv [8], m_cpu [8];
    int m_cnt = 0;
    bit m_valid = 0, m_nex = 0, m_insvc = 0, m_isx = 0;

    task automatic chk(string tag, int act, int exp, string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic t_alloc(int id, bit ex, bit unc, logic [31:0] a, int sz);
        @(negedge clk);
        alloc_valid = 1; alloc_id = 4'(id); alloc_excl = ex; alloc_inval = 0;
        alloc_uncached = unc; alloc_addr = a; alloc_size = 3'(sz);
        @(negedge clk);
        alloc_valid = 0;
        if (!m_valid) begin
            m_valid = 1; m_cnt = 1; m_nex = ex; m_insvc = 0; m_isx = 0;
            m_id[0] = id; m_ex[0] = ex; m_inv[0] = 0; m_cpu[0] = 1;
            chk("R1", int'(line_addr), int'(a), "line_addr");
            chk("R1", int'(uncacheable), int'(unc), "uncacheable");
        end
        chk("R1", int'(tgt_count), m_cnt, "count after alloc");
        chk("R1", int'(needs_excl), int'(m_nex), "needs_excl after alloc");
    endtask

    task automatic t_add(string tag, int id, bit ex, bit inv, bit cpu);
        bit spec, full;
        int pos;
        full = (m_cnt == 8);
        spec = m_insvc && !m_isx && m_nex && !cpu && inv;
        pos = m_cnt;
        if (spec)
            for (int i = m_cnt - 1; i >= 0; i--) if (m_ex[i]) pos = i;
        @(negedge clk);
        add_valid = 1; add_id = 4'(id); add_excl = ex; add_inval = inv; add_cpu = cpu;
        @(negedge clk);
        add_valid = 0;
        if (!full) begin
            for (int i = m_cnt; i > pos; i--) begin
                m_id[i] = m_id[i-1]; m_ex[i] = m_ex[i-1];
                m_inv[i] = m_inv[i-1]; m_cpu[i] = m_cpu[i-1];
            end
            m_id[pos] = id; m_ex[pos] = ex; m_inv[pos] = inv; m_cpu[pos] = cpu;
            m_cnt++;
            m_nex = m_nex | ex;
        end
        chk("R9", int'(add_err), int'(full), "add_err");
        chk("R3", int'(tgt_count), m_cnt, {tag, " count after add"});
        chk("R6", int'(needs_excl), int'(m_nex), "sticky needs_excl");
    endtask

    task automatic t_pop(string tag);
        bit empty;
        empty = (m_cnt == 0);
        @(negedge clk);
        pop_valid = 1;
        @(negedge clk);
        pop_valid = 0;
        chk("R8", int'(pop_err), int'(empty), "pop_err");
        chk("R8", int'(pop_ack), int'(!empty), "pop_ack");
        if (!empty) begin
            chk(tag, int'(pop_id), m_id[0], "popped id");
            chk(tag, int'(pop_excl), int'(m_ex[0]), "popped excl");
            chk(tag, int'(pop_inval), int'(m_inv[0]), "popped inval");
            chk(tag, int'(pop_cpu), int'(m_cpu[0]), "popped side");
            for (int i = 0; i < 7; i++) begin
                m_id[i] = m_id[i+1]; m_ex[i] = m_ex[i+1];
                m_inv[i] = m_inv[i+1]; m_cpu[i] = m_cpu[i+1];
            end
            m_cnt--;
        end
        chk("R8", int'(tgt_count), m_cnt, "count after pop");
    endtask

    task automatic t_issue(bit ex);
        @(negedge clk);
        issue_valid = 1; issue_excl = ex;
        @(negedge clk);
        issue_valid = 0;
        m_insvc = 1; m_isx = ex;
        chk("R7", int'(in_service), 1, "in_service");
        chk("R7", int'(issued_excl), int'(ex), "issued_excl");
    endtask

    task automatic t_dealloc();
        @(negedge clk);
        dealloc_valid = 1;
        @(negedge clk);
        dealloc_valid = 0;
        if (m_cnt == 0) begin m_valid = 0; m_insvc = 0; end
        chk("R10", int'(entry_valid), int'(m_valid), "entry_valid after release");
        chk("R10", int'(in_service), int'(m_insvc), "in_service after release");
    endtask

    task automatic drain(string tag);
        while (m_cnt > 0) t_pop(tag);
        t_dealloc();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1", int'(entry_valid), 0, "reset entry_valid");
        chk("R1", int'(tgt_count), 0, "reset count");
        chk("R1", int'(in_service), 0, "reset in_service");

        // Pop on an empty entry is refused
        t_pop("R8");

        // R1/R2: allocate, then a second allocate is ignored
        t_alloc(3, 0, 1, 32'h0000_1240, 5);
        t_alloc(4, 1, 0, 32'h0000_9990, 2);
        chk("R2", int'(line_addr), 32'h0000_1240, "addr after busy alloc");
        chk("R2", int'(line_size), 5, "size after busy alloc");
        // R10: release with requests queued is ignored
        t_dealloc();
        chk("R10", int'(entry_valid), 1, "busy release ignored");
        t_pop("R1");
        t_dealloc();

        // R4: first ownership request at each position, snoop invalidate inserted
        for (int p = 0; p <= 6; p++) begin
            t_alloc(0, (p == 0), 0, 32'h100 * p, 3);
            for (int j = 1; j < 6; j++) t_add("R3", j, (j >= p), 0, 1);
            t_issue(0);
            t_add("R4", 9, 0, 1, 0);
            drain("R4");
        end

        // R5: all 32 combinations of the five enabling conditions
        for (int c = 0; c < 32; c++) begin
            t_alloc(0, 0, 0, 32'h4000 + c, 1);
            t_add("R3", 1, c[2], 0, 1);
            t_add("R3", 2, 0, 0, 1);
            if (c[0]) t_issue(c[1]);
            t_add("R5", 7, 0, c[4], !c[3]);
            drain("R5");
        end

        // R9: fill to capacity, reject one more, verify the list is intact
        t_alloc(0, 0, 0, 32'h8000, 0);
        for (int j = 1; j < 8; j++) t_add("R9", j, j[0], 0, j[1]);
        chk("R9", int'(list_full), 1, "list_full at capacity");
        t_add("R9", 15, 1, 1, 0);
        drain("R9");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule